// File: doc/BRIEF.md
# Top-of-Book Register Cache

This block keeps the eight best price levels of each side of one instrument's book in flip-flops. It never reads the large level store behind it. Each incoming event carries a side, a price and a quantity, and the block accepts one event on every clock with no stall. The event's price is compared at once against all slots of its side, and the event then takes one of five named actions:

- **ACT_HIT**: a slot already holds that price, and the event's quantity is added to that slot.
- **ACT_FILL**: no slot matches and the side has a free slot, so the level is placed in the lowest-numbered free slot.
- **ACT_EVICT**: no slot matches and the side is full. The price is better than the side's worst slot, so the worst level is pushed out to the store port and the new level takes its slot.
- **ACT_SPILL**: no slot matches and the side is full. The price is worse than every slot, so the event itself goes to the store port.
- **ACT_BYPASS**: the price lies outside the cached window, so the event goes straight to the store port.

A cycle without an event is **ACT_IDLE**. The action is chosen in a single cycle and is not kept between events. Every action's result is registered at the clock edge that accepts the event.

The store port is write-only. It gives a level's price and quantity together with a row address derived from the price, and nothing is ever read back. A snapshot of best bid and best ask, each with a price, a quantity and a valid flag, is held in registers. All of its fields change on the same edge, so any reader sees one consistent view.

Top module: `tnb_book`

## Requirements
- R1: While reset is held and in the first cycle after it, every slot is empty, `bb_valid`, `ba_valid` and `st_valid` are 0, and all snapshot and store data outputs are 0.
- R2: An in-window event (`ev_side` 0 = bid, 1 = ask) whose price equals an occupied slot of its side adds `ev_qty` to that slot's quantity, modulo 2^32. It raises no store write in the next cycle.
- R3: An in-window event that matches no slot, on a side with a free slot, occupies a free slot with its price and quantity. It raises no store write.
- R4: An in-window event that matches no slot, on a full side, with a price strictly better than the side's worst slot (above the lowest bid, or below the highest ask), puts that worst slot's price and quantity on the store port in the next cycle and replaces that slot with the event.
- R5: An in-window event that matches no slot, on a full side, with a price worse than every slot of that side, puts its own price and quantity on the store port in the next cycle and leaves the slots unchanged.
- R6: An event whose price is below `win_lo` or above `win_hi` (both bounds inclusive-in) puts its own price and quantity on the store port in the next cycle and leaves the slots unchanged.
- R7: `st_addr` equals bits [FRAC_W+ADDR_W-1 : FRAC_W] of ((`st_price` − `base_price`) mod 2^32) × `tick_recip`, with FRAC_W = 16 and ADDR_W = 10.
- R8: In the cycle after any event, the snapshot shows the highest occupied bid and the lowest occupied ask, each with its quantity. A side with no occupied slot shows valid 0, price 0 and quantity 0.
- R9: An event is accepted on every cycle that `ev_valid` is high. A cycle with `ev_valid` low leaves the snapshot unchanged and drives `st_valid` low.
- R10: The prices held in the occupied slots of one side are always distinct, so at most one slot matches an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_side | input | 1 | 0 = bid, 1 = ask |
| ev_price | input | 32 | Event price |
| ev_qty | input | 32 | Event quantity |
| base_price | input | 32 | Price mapped to store row 0 |
| tick_recip | input | 18 | Reciprocal of the tick size, 16 fraction bits |
| win_lo | input | 32 | Lowest price that is cached |
| win_hi | input | 32 | Highest price that is cached |
| st_valid | output | 1 | Store write strobe |
| st_addr | output | 10 | Store row address |
| st_price | output | 32 | Price written to the store |
| st_qty | output | 32 | Quantity written to the store |
| bb_valid | output | 1 | Best bid present |
| bb_price | output | 32 | Best bid price |
| bb_qty | output | 32 | Best bid quantity |
| ba_valid | output | 1 | Best ask present |
| ba_price | output | 32 | Best ask price |
| ba_qty | output | 32 | Best ask quantity |

## Verification
The assertions assume that `base_price`, `tick_recip`, `win_lo` and `win_hi` are static while events flow, and that `win_lo` is not above `win_hi`. The stimulus sets these once before reset is released and never changes them. The assertions also assume that quantities accumulated on a level do not wrap. The stimulus keeps every quantity between 1 and 50 over a bounded run, so no level comes near 2^32. Prices are drawn on a 4-unit grid inside the window, with a minority deliberately outside it, so that all five actions and the idle cycle occur many times.

// File: rtl/tnb_pkg.sv
package tnb_pkg;
    localparam int PRICE_W = 32;
    localparam int QTY_W   = 32;

    typedef struct packed {
        logic               valid;
        logic [PRICE_W-1:0] price;
        logic [QTY_W-1:0]   qty;
    } level_t;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_HIT,
        ACT_FILL,
        ACT_EVICT,
        ACT_SPILL,
        ACT_BYPASS
    } act_e;
endpackage

// File: rtl/tnb_side_scan.sv
module tnb_side_scan
    import tnb_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter bit IS_ASK = 1'b0,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  level_t [SLOTS-1:0]       lvl,
    input  logic [PRICE_W-1:0]       price,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_idx,
    output logic                     full,
    output logic [IDX_W-1:0]         free_idx,
    output logic [IDX_W-1:0]         worst_idx,
    output logic                     better
);
    logic [SLOTS-1:0]   match_vec;
    logic [PRICE_W-1:0] worst_p;

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        full     = 1'b1;
        for (int i = 0; i < SLOTS; i++) begin
            match_vec[i] = lvl[i].valid && (lvl[i].price == price);
            if (match_vec[i]) hit_idx = IDX_W'(i);
            if (!lvl[i].valid) full = 1'b0;
        end
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!lvl[i].valid) free_idx = IDX_W'(i);
        end
        hit = |match_vec;
    end

    // Worst-slot reduction: lowest bid or highest ask (used only when full).
    always_comb begin
        worst_idx = '0;
        worst_p   = lvl[0].price;
        for (int i = 1; i < SLOTS; i++) begin
            if (IS_ASK ? (lvl[i].price > worst_p) : (lvl[i].price < worst_p)) begin
                worst_idx = IDX_W'(i);
                worst_p   = lvl[i].price;
            end
        end
        better = IS_ASK ? (price < worst_p) : (price > worst_p);
    end

    // R10: occupied prices of a side stay distinct.
    p_unique_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));
endmodule

// File: rtl/tnb_best_pick.sv
module tnb_best_pick
    import tnb_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter bit IS_ASK = 1'b0
) (
    input  level_t [SLOTS-1:0] lvl,
    output logic               found,
    output logic [PRICE_W-1:0] best_price,
    output logic [QTY_W-1:0]   best_qty
);
    always_comb begin
        found      = 1'b0;
        best_price = '0;
        best_qty   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (lvl[i].valid && (!found ||
                (IS_ASK ? (lvl[i].price < best_price) : (lvl[i].price > best_price)))) begin
                found      = 1'b1;
                best_price = lvl[i].price;
                best_qty   = lvl[i].qty;
            end
        end
    end
endmodule

// File: rtl/tnb_addr_calc.sv
module tnb_addr_calc
    import tnb_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int RECIP_W = 18,
    parameter int FRAC_W  = 16,
    localparam int PROD_W = PRICE_W + RECIP_W
) (
    input  logic [PRICE_W-1:0] price,
    input  logic [PRICE_W-1:0] base_price,
    input  logic [RECIP_W-1:0] tick_recip,
    output logic [ADDR_W-1:0]  addr
);
    logic [PRICE_W-1:0] diff;
    logic [PROD_W-1:0]  prod;

    always_comb begin
        diff = price - base_price;
        prod = PROD_W'(diff) * PROD_W'(tick_recip);
        addr = prod[FRAC_W +: ADDR_W];
    end
endmodule

// File: rtl/tnb_book.sv
module tnb_book
    import tnb_pkg::*;
#(
    parameter int SLOTS   = 8,
    parameter int ADDR_W  = 10,
    parameter int RECIP_W = 18,
    parameter int FRAC_W  = 16,
    localparam int IDX_W  = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic               ev_side,
    input  logic [31:0]        ev_price,
    input  logic [31:0]        ev_qty,
    input  logic [31:0]        base_price,
    input  logic [RECIP_W-1:0] tick_recip,
    input  logic [31:0]        win_lo,
    input  logic [31:0]        win_hi,
    output logic               st_valid,
    output logic [ADDR_W-1:0]  st_addr,
    output logic [31:0]        st_price,
    output logic [31:0]        st_qty,
    output logic               bb_valid,
    output logic [31:0]        bb_price,
    output logic [31:0]        bb_qty,
    output logic               ba_valid,
    output logic [31:0]        ba_price,
    output logic [31:0]        ba_qty
);
    level_t [SLOTS-1:0] book_q [2];
    level_t [SLOTS-1:0] book_d [2];

    logic             sc_hit    [2];
    logic [IDX_W-1:0] sc_hit_idx[2];
    logic             sc_full   [2];
    logic [IDX_W-1:0] sc_free   [2];
    logic [IDX_W-1:0] sc_worst  [2];
    logic             sc_better [2];

    logic               bp_found[2];
    logic [PRICE_W-1:0] bp_price[2];
    logic [QTY_W-1:0]   bp_qty  [2];

    act_e               act;
    logic               in_win;
    logic               st_valid_d;
    logic [PRICE_W-1:0] st_price_d;
    logic [QTY_W-1:0]   st_qty_d;
    logic [ADDR_W-1:0]  st_addr_d;

    for (genvar s = 0; s < 2; s++) begin : g_side
        tnb_side_scan #(.SLOTS(SLOTS), .IS_ASK(s == 1)) u_scan (
            .clk(clk), .rst_n(rst_n), .lvl(book_q[s]), .price(ev_price),
            .hit(sc_hit[s]), .hit_idx(sc_hit_idx[s]), .full(sc_full[s]),
            .free_idx(sc_free[s]), .worst_idx(sc_worst[s]), .better(sc_better[s])
        );
        tnb_best_pick #(.SLOTS(SLOTS), .IS_ASK(s == 1)) u_best (
            .lvl(book_d[s]), .found(bp_found[s]),
            .best_price(bp_price[s]), .best_qty(bp_qty[s])
        );
    end

    tnb_addr_calc #(.ADDR_W(ADDR_W), .RECIP_W(RECIP_W), .FRAC_W(FRAC_W)) u_addr (
        .price(st_price_d), .base_price(base_price),
        .tick_recip(tick_recip), .addr(st_addr_d)
    );

    // Action decode.
    always_comb begin
        in_win = (ev_price >= win_lo) && (ev_price <= win_hi);
        if (!ev_valid)                act = ACT_IDLE;
        else if (!in_win)             act = ACT_BYPASS;
        else if (sc_hit[ev_side])     act = ACT_HIT;
        else if (!sc_full[ev_side])   act = ACT_FILL;
        else if (sc_better[ev_side])  act = ACT_EVICT;
        else                          act = ACT_SPILL;
    end

    // Next book and store write per action.
    always_comb begin
        book_d     = book_q;
        st_valid_d = 1'b0;
        st_price_d = ev_price;
        st_qty_d   = ev_qty;
        unique case (act)
            ACT_IDLE: ;
            ACT_HIT: begin
                book_d[ev_side][sc_hit_idx[ev_side]].qty =
                    book_q[ev_side][sc_hit_idx[ev_side]].qty + ev_qty;
            end
            ACT_FILL: begin
                book_d[ev_side][sc_free[ev_side]] = '{valid: 1'b1, price: ev_price, qty: ev_qty};
            end
            ACT_EVICT: begin
                st_valid_d = 1'b1;
                st_price_d = book_q[ev_side][sc_worst[ev_side]].price;
                st_qty_d   = book_q[ev_side][sc_worst[ev_side]].qty;
                book_d[ev_side][sc_worst[ev_side]] = '{valid: 1'b1, price: ev_price, qty: ev_qty};
            end
            ACT_SPILL, ACT_BYPASS: begin
                st_valid_d = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) book_q[s] <= '0;
            st_valid <= 1'b0;
            st_addr  <= '0;
            st_price <= '0;
            st_qty   <= '0;
            bb_valid <= 1'b0;
            bb_price <= '0;
            bb_qty   <= '0;
            ba_valid <= 1'b0;
            ba_price <= '0;
            ba_qty   <= '0;
        end else begin
            for (int s = 0; s < 2; s++) book_q[s] <= book_d[s];
            st_valid <= st_valid_d;
            st_addr  <= st_valid_d ? st_addr_d  : '0;
            st_price <= st_valid_d ? st_price_d : '0;
            st_qty   <= st_valid_d ? st_qty_d   : '0;
            bb_valid <= bp_found[0];
            bb_price <= bp_price[0];
            bb_qty   <= bp_qty[0];
            ba_valid <= bp_found[1];
            ba_price <= bp_price[1];
            ba_qty   <= bp_qty[1];
        end
    end

    // R6: out-of-window events go to the store unchanged.
    p_bypass_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !in_win) |=> (st_valid && st_price == $past(ev_price)
                                   && st_qty == $past(ev_qty)));

    // R2: a hit raises no store write.
    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && in_win && sc_hit[ev_side]) |=> !st_valid);

    // R3: filling a free slot raises no store write.
    p_fill_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && in_win && !sc_hit[ev_side] && !sc_full[ev_side]) |=> !st_valid);

    // R4: an eviction writes out a level other than the incoming one.
    p_evict_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_EVICT) |=> (st_valid && st_price != $past(ev_price)));

    // R5: a spilled event is written out as received.
    p_spill_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_SPILL) |=> (st_valid && st_price == $past(ev_price)));

    // R9: an idle cycle leaves the snapshot alone.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> (!st_valid && $stable(bb_valid) && $stable(bb_price) && $stable(bb_qty)
                       && $stable(ba_valid) && $stable(ba_price) && $stable(ba_qty)));
endmodule

// File: tb/sim_tnb_book.sv
module sim_tnb_book;
    localparam int  N_SLOTS = 8;
    localparam int  BASE    = 1000;
    localparam int  RECIP   = 16384;   // tick of 4, 16 fraction bits
    localparam int  WLO     = 1000;
    localparam int  WHI     = 1400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_side = 1'b0;
    logic [31:0] ev_price = '0;
    logic [31:0] ev_qty = '0;
    logic        st_valid;
    logic [9:0]  st_addr;
    logic [31:0] st_price, st_qty, bb_price, bb_qty, ba_price, ba_qty;
    logic        bb_valid, ba_valid;

    always #10 clk = ~clk;   // 50 MHz

    tnb_book u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_side(ev_side),
        .ev_price(ev_price), .ev_qty(ev_qty), .base_price(32'(BASE)),
        .tick_recip(18'(RECIP)), .win_lo(32'(WLO)), .win_hi(32'(WHI)),
        .st_valid(st_valid), .st_addr(st_addr), .st_price(st_price), .st_qty(st_qty),
        .bb_valid(bb_valid), .bb_price(bb_price), .bb_qty(bb_qty),
        .ba_valid(ba_valid), .ba_price(ba_price), .ba_qty(ba_qty)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct { int unsigned p; int unsigned q; } lv_t;
    lv_t book[2][$];

    bit          e_st_v;
    int unsigned e_st_p, e_st_q;
    string       tag;

    function automatic int unsigned addr_of(int unsigned p);
        longint unsigned d = longint'(32'(p - BASE));
        return int'(((d * RECIP) >> 16) & 10'h3FF);
    endfunction

    task automatic chk(string t, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    task automatic model(bit v, bit s, int unsigned p, int unsigned q);
        e_st_v = 1'b0; e_st_p = 0; e_st_q = 0; tag = "R9";
        if (!v) return;
        if (p < WLO || p > WHI) begin
            e_st_v = 1; e_st_p = p; e_st_q = q; tag = "R6"; return;
        end
        foreach (book[s][i]) if (book[s][i].p == p) begin
            book[s][i].q += q; tag = "R2,R10"; return;
        end
        if (book[s].size() < N_SLOTS) begin
            book[s].push_back('{p, q}); tag = "R3"; return;
        end
        begin
            int w = 0;
            for (int i = 1; i < book[s].size(); i++)
                if (s ? book[s][i].p > book[s][w].p : book[s][i].p < book[s][w].p) w = i;
            if (s ? p < book[s][w].p : p > book[s][w].p) begin
                e_st_v = 1; e_st_p = book[s][w].p; e_st_q = book[s][w].q;
                book[s][w] = '{p, q}; tag = "R4";
            end else begin
                e_st_v = 1; e_st_p = p; e_st_q = q; tag = "R5";
            end
        end
    endtask

    task automatic compare_all(string t);
        bit bv = 0, av = 0;
        int unsigned bp = 0, bq = 0, ap = 0, aq = 0;
        foreach (book[0][i]) if (!bv || book[0][i].p > bp) begin bv = 1; bp = book[0][i].p; bq = book[0][i].q; end
        foreach (book[1][i]) if (!av || book[1][i].p < ap) begin av = 1; ap = book[1][i].p; aq = book[1][i].q; end
        chk(t, "st_valid", st_valid, e_st_v);
        if (e_st_v) begin
            chk(t, "st_price", st_price, e_st_p);
            chk(t, "st_qty", st_qty, e_st_q);
            chk("R7", "st_addr", st_addr, addr_of(e_st_p));
        end
        chk("R8", "bb_valid", bb_valid, bv);
        chk("R8", "bb_price", bb_price, bp);
        chk("R8", "bb_qty", bb_qty, bq);
        chk("R8", "ba_valid", ba_valid, av);
        chk("R8", "ba_price", ba_price, ap);
        chk("R8", "ba_qty", ba_qty, aq);
    endtask

    // One cycle: drive at negedge, absorb at posedge, compare at next negedge.
    task automatic step(bit v, bit s, int unsigned p, int unsigned q);
        ev_valid = v; ev_side = s; ev_price = p; ev_qty = q;
        @(posedge clk);
        model(v, s, p, q);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset.
        chk("R1", "st_valid", st_valid, 0);
        chk("R1", "bb_valid", bb_valid, 0);
        chk("R1", "ba_valid", ba_valid, 0);
        chk("R1", "bb_price", bb_price, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ba_qty", ba_qty, 0);
        e_st_v = 0;
        compare_all("R1");

        // Bid side: fill, hit the worst level, evict it, spill, bypass.
        for (int i = 0; i < 8; i++) step(1, 0, 1100 + 4 * i, 10 + i);
        step(1, 0, 1100, 5);
        step(1, 0, 1200, 7);
        step(1, 0, 1050, 3);
        step(1, 0, 1128, 2);
        step(1, 0, 990, 4);
        step(1, 0, 1404, 6);
        step(1, 0, 1400, 9);   // in window (upper bound inclusive), evicts
        // Ask side.
        for (int i = 0; i < 8; i++) step(1, 1, 1300 + 4 * i, 20 + i);
        step(1, 1, 1250, 8);
        step(1, 1, 1390, 1);
        step(1, 1, 1000, 2);   // lower bound inclusive, evicts
        step(0, 0, 1200, 99);
        step(0, 1, 1100, 99);

        // Random traffic.
        for (int n = 0; n < 3000; n++) begin
            int unsigned p;
            int r = $urandom_range(0, 99);
            if (r < 6) p = 900 + 4 * $urandom_range(0, 24);
            else if (r < 12) p = 1404 + 4 * $urandom_range(0, 24);
            else p = 1000 + 4 * $urandom_range(0, 100);
            step($urandom_range(0, 99) < 85, 1'($urandom_range(0, 1)), p, $urandom_range(1, 50));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule